// File: doc/BRIEF.md
# Float Zero-Compare Branch Unit

This combinational block settles floating-point branches and floating-point conditional moves. Each of these instructions tests one 64-bit register value against zero. The sign bit alone, set over an all-zero magnitude, is negative zero, and it must behave exactly like positive zero in every condition.

For a branch, the block returns the next program counter. That is either the incremented PC it was given or that PC plus a sign-extended word displacement. For a conditional move, it returns a write enable and the data for the destination register. Opcodes or function codes outside the supported sets raise an invalid flag, and in that case the block makes no write and no redirect. All outputs are ready in the same cycle as the inputs.

Top module: `fzero_branch_unit`

## Requirements
- R1: Equal and not-equal ignore bit 63 and test whether bits 62..0 are all zero, so patterns 0x0 and 0x8000000000000000 are both equal to zero.
- R2: Less-or-equal and greater-than are a signed 64-bit comparison with zero; negative zero is less-or-equal and not greater-than.
- R3: Greater-or-equal holds when the value is signed non-negative or is exactly 0x8000000000000000.
- R4: Less-than holds when the value is signed negative and is not 0x8000000000000000.
- R5: Branch major opcodes: 0x31 equal, 0x32 less-than, 0x33 less-or-equal, 0x35 not-equal, 0x36 greater-or-equal, 0x37 greater-than, tested on the first source.
- R6: A taken branch gives next PC = incremented PC + (sign-extended 21-bit displacement << 2). A branch that is not taken gives the incremented PC.
- R7: A conditional move is major opcode 0x17 with function 0x02A equal, 0x02B not-equal, 0x02C less-than, 0x02D greater-or-equal, 0x02E less-or-equal, 0x02F greater-than, tested on the first source.
- R8: A conditional move whose condition holds asserts the write enable with the second source's value as data. Otherwise the write enable is low and the data is zero.
- R9: Register index 31 reads as zero for both the tested source and the second source.
- R10: A conditional move whose destination index is 31 never asserts the write enable.
- R11: Any other opcode, or opcode 0x17 with any other function code, raises invalid, keeps the write enable low and leaves the next PC at the incremented PC.
- R12: A branch never writes, and a conditional move never changes the next PC from the incremented PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode |
| func | input | 11 | Function code for opcode 0x17 |
| ra_idx | input | 5 | Index of the tested source |
| rb_idx | input | 5 | Index of the moved source |
| rc_idx | input | 5 | Destination index |
| ra_val | input | 64 | Tested register value |
| rb_val | input | 64 | Moved register value |
| pc_inc | input | 64 | Already-incremented PC |
| disp | input | 21 | Branch word displacement |
| next_pc | output | 64 | Next program counter |
| wr_en | output | 1 | Destination write enable |
| wr_data | output | 64 | Destination write data |
| invalid | output | 1 | Unsupported opcode or function |

## Verification
The bench aims at negative zero under all six conditions. A design that compared the raw signed value would treat it as not equal to zero and less than zero, and would drop it from greater-or-equal. The bench uses the tested value with index 31, together with nonzero register contents, to catch a design that reads the port instead of zero. It also covers a move whose condition holds but whose destination is 31, and the case where the second source would be moved instead of the tested one. The extreme positive and negative displacements expose sign-extension or shift errors in the branch target. Infinities, NaNs and the smallest denormals check that the full 63-bit magnitude is tested.

// File: rtl/fzero_branch_unit.sv
module fzero_branch_unit #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 21,
  parameter int RIDX_W = 5
) (
  input  logic [5:0]        opcode,
  input  logic [10:0]       func,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [RIDX_W-1:0] rb_idx,
  input  logic [RIDX_W-1:0] rc_idx,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [XLEN-1:0]   pc_inc,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   next_pc,
  output logic              wr_en,
  output logic [XLEN-1:0]   wr_data,
  output logic              invalid
);
  localparam logic [RIDX_W-1:0] ZREG  = '1;
  localparam logic [XLEN-1:0]   NEGZ  = {1'b1, {(XLEN-1){1'b0}}};
  localparam int                EXT_W = XLEN - DISP_W - 2;

  typedef enum logic [2:0] {C_EQ, C_NE, C_LT, C_LE, C_GT, C_GE} cond_t;

  function automatic logic zero_test(cond_t c, logic [XLEN-1:0] v);
    logic mag_zero;
    mag_zero = ~|v[XLEN-2:0];
    case (c)
      C_EQ:    return mag_zero;
      C_NE:    return !mag_zero;
      C_LE:    return $signed(v) <= 0;
      C_GT:    return $signed(v) > 0;
      C_GE:    return ($signed(v) >= 0) || (v == NEGZ);
      default: return ($signed(v) < 0) && (v != NEGZ);
    endcase
  endfunction

  logic            is_br, is_mv, hit;
  cond_t           cond;
  logic [XLEN-1:0] a_eff, b_eff, target;

  always_comb begin
    is_br = 1'b0;
    is_mv = 1'b0;
    cond  = C_EQ;
    case (opcode)
      6'h31: begin is_br = 1'b1; cond = C_EQ; end
      6'h32: begin is_br = 1'b1; cond = C_LT; end
      6'h33: begin is_br = 1'b1; cond = C_LE; end
      6'h35: begin is_br = 1'b1; cond = C_NE; end
      6'h36: begin is_br = 1'b1; cond = C_GE; end
      6'h37: begin is_br = 1'b1; cond = C_GT; end
      6'h17: begin
        case (func)
          11'h02A: begin is_mv = 1'b1; cond = C_EQ; end
          11'h02B: begin is_mv = 1'b1; cond = C_NE; end
          11'h02C: begin is_mv = 1'b1; cond = C_LT; end
          11'h02D: begin is_mv = 1'b1; cond = C_GE; end
          11'h02E: begin is_mv = 1'b1; cond = C_LE; end
          11'h02F: begin is_mv = 1'b1; cond = C_GT; end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign a_eff   = (ra_idx == ZREG) ? '0 : ra_val;
  assign b_eff   = (rb_idx == ZREG) ? '0 : rb_val;
  assign hit     = zero_test(cond, a_eff);
  assign target  = pc_inc + {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign next_pc = (is_br && hit) ? target : pc_inc;
  assign wr_en   = is_mv && hit && (rc_idx != ZREG);
  assign wr_data = wr_en ? b_eff : '0;
  assign invalid = !(is_br || is_mv);

  always_comb begin
    // R1 R2 R3 R4: the sign-only pattern must give the same answer as +0.0
    if (a_eff == NEGZ)
      assert_negzero_R4: assert (hit == zero_test(cond, '0));
    if (invalid)
      assert_invalid_quiet_R11: assert (!wr_en && next_pc == pc_inc);
    if (rc_idx == ZREG)
      assert_zero_dest_R10: assert (!wr_en);
    if (is_br)
      assert_branch_nowrite_R12: assert (!wr_en);
    if (is_mv)
      assert_move_noredirect_R12: assert (next_pc == pc_inc);
    if (!wr_en)
      assert_idle_data_R8: assert (wr_data == '0);
  end
endmodule

// File: tb/tb_fzero_branch_unit.sv
module tb_fzero_branch_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [5:0]  opcode = '0;
  logic [10:0] func = '0;
  logic [4:0]  ra_idx = '0, rb_idx = '0, rc_idx = '0;
  logic [63:0] ra_val = '0, rb_val = '0, pc_inc = '0;
  logic [20:0] disp = '0;
  logic [63:0] next_pc, wr_data;
  logic        wr_en, invalid;

  int checks = 0, errors = 0;
  bit done = 0;

  fzero_branch_unit dut (
    .opcode(opcode), .func(func), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .rc_idx(rc_idx), .ra_val(ra_val), .rb_val(rb_val), .pc_inc(pc_inc),
    .disp(disp), .next_pc(next_pc), .wr_en(wr_en), .wr_data(wr_data),
    .invalid(invalid)
  );

  // 0 none,1 eq,2 ne,3 lt,4 le,5 gt,6 ge
  function automatic int br_kind(logic [5:0] op);
    case (op)
      6'h31: return 1; 6'h32: return 3; 6'h33: return 4;
      6'h35: return 2; 6'h36: return 6; 6'h37: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int mv_kind(logic [5:0] op, logic [10:0] fn);
    if (op != 6'h17) return 0;
    case (fn)
      11'h02A: return 1; 11'h02B: return 2; 11'h02C: return 3;
      11'h02D: return 6; 11'h02E: return 4; 11'h02F: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_cond(int k, logic [63:0] v);
    bit z, n;
    z = (v[62:0] == 63'd0);
    n = v[63];
    case (k)
      1: return z;
      2: return !z;
      3: return n && !z;
      4: return n || z;
      5: return !n && !z;
      default: return !n || z;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run(string tag, logic [5:0] op, logic [10:0] fn,
                     logic [4:0] a, logic [4:0] b, logic [4:0] c,
                     logic [63:0] av, logic [63:0] bv, logic [63:0] pc,
                     logic [20:0] d);
    int bk, mk;
    bit t;
    logic [63:0] ae, be, e_pc, e_data;
    bit e_we, e_inv;
    @(negedge clk);
    opcode = op; func = fn; ra_idx = a; rb_idx = b; rc_idx = c;
    ra_val = av; rb_val = bv; pc_inc = pc; disp = d;
    #1;
    bk = br_kind(op);
    mk = mv_kind(op, fn);
    ae = (a == 5'd31) ? 64'd0 : av;
    be = (b == 5'd31) ? 64'd0 : bv;
    e_pc = pc; e_we = 0; e_data = 0; e_inv = (bk == 0 && mk == 0);
    if (bk != 0) begin
      t = ref_cond(bk, ae);
      if (t) e_pc = pc + 64'($signed(d)) * 64'd4;
    end
    if (mk != 0) begin
      t = ref_cond(mk, ae);
      e_we = t && (c != 5'd31);
      e_data = e_we ? be : 64'd0;
    end
    chk(tag, next_pc, e_pc, "next_pc");
    chk(tag, {63'd0, wr_en}, {63'd0, e_we}, "wr_en");
    chk(tag, wr_data, e_data, "wr_data");
    chk(tag, {63'd0, invalid}, {63'd0, e_inv}, "invalid");
  endtask

  logic [63:0] pool [12];
  logic [5:0]  bops [6];
  initial begin
    pool[0] = 64'h0;                pool[1] = 64'h8000000000000000;
    pool[2] = 64'h0000000000000001; pool[3] = 64'h8000000000000001;
    pool[4] = 64'h7FF0000000000000; pool[5] = 64'hFFF0000000000000;
    pool[6] = 64'h7FF8000000000000; pool[7] = 64'hFFF8000000000001;
    pool[8] = 64'h3FF0000000000000; pool[9] = 64'hBFF0000000000000;
    pool[10] = 64'h7FFFFFFFFFFFFFFF; pool[11] = 64'hFFFFFFFFFFFFFFFF;
    bops[0] = 6'h31; bops[1] = 6'h32; bops[2] = 6'h33;
    bops[3] = 6'h35; bops[4] = 6'h36; bops[5] = 6'h37;
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    #2;
    // reset-like idle state: opcode 0 is unsupported
    chk("R11", {63'd0, invalid}, 64'd1, "idle invalid");
    chk("R11", {63'd0, wr_en}, 64'd0, "idle wr_en");

    // R1 R2 R3 R4 R5: every branch on +0.0 and -0.0
    for (int i = 0; i < 6; i++) begin
      run("R1", bops[i], 11'h0, 5'd1, 5'd2, 5'd3, 64'h0, 64'h5, 64'h1000, 21'h000010);
      run("R4", bops[i], 11'h0, 5'd1, 5'd2, 5'd3, 64'h8000000000000000, 64'h5, 64'h1000, 21'h000010);
      run("R3", bops[i], 11'h0, 5'd1, 5'd2, 5'd3, 64'h8000000000000001, 64'h5, 64'h1000, 21'h000010);
      run("R2", bops[i], 11'h0, 5'd1, 5'd2, 5'd3, 64'h0000000000000001, 64'h5, 64'h1000, 21'h000010);
    end
    // R6: extreme displacements on a taken branch
    run("R6", 6'h31, 11'h0, 5'd31, 5'd2, 5'd3, 64'h1, 64'h0, 64'h0000_0000_8000_0000, 21'h0FFFFF);
    run("R6", 6'h31, 11'h0, 5'd31, 5'd2, 5'd3, 64'h1, 64'h0, 64'h0000_0000_8000_0000, 21'h100000);
    // R9: tested index 31 reads zero despite nonzero port value
    run("R9", 6'h35, 11'h0, 5'd31, 5'd2, 5'd3, 64'hDEAD, 64'h0, 64'h2000, 21'h4);
    // R7 R8: moves on -0.0, second source moved
    for (int f = 11'h02A; f <= 11'h02F; f++) begin
      run("R7", 6'h17, 11'(f), 5'd4, 5'd5, 5'd6, 64'h8000000000000000, 64'hCAFE_F00D_1234_5678, 64'h40, 21'h0);
      run("R8", 6'h17, 11'(f), 5'd4, 5'd5, 5'd6, 64'hBFF0000000000000, 64'h0123_4567_89AB_CDEF, 64'h40, 21'h0);
    end
    // R9: second source 31 writes zero
    run("R9", 6'h17, 11'h02A, 5'd4, 5'd31, 5'd6, 64'h0, 64'hFFFF, 64'h40, 21'h0);
    // R10: destination 31 never written
    run("R10", 6'h17, 11'h02D, 5'd4, 5'd5, 5'd31, 64'h0, 64'hFFFF, 64'h40, 21'h0);
    // R11: unsupported opcode and function codes
    run("R11", 6'h34, 11'h0, 5'd31, 5'd5, 5'd6, 64'h0, 64'h1, 64'h80, 21'h7);
    run("R11", 6'h17, 11'h030, 5'd31, 5'd5, 5'd6, 64'h0, 64'h1, 64'h80, 21'h7);
    run("R11", 6'h17, 11'h029, 5'd31, 5'd5, 5'd6, 64'h0, 64'h1, 64'h80, 21'h7);

    // R12 and general: constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] op; logic [10:0] fn; logic [63:0] av, bv, pc; logic [20:0] d;
      int sel;
      sel = int'($urandom_range(0, 9));
      fn = 11'($urandom_range(11'h028, 11'h031));
      if (sel < 5) op = bops[$urandom_range(0, 5)];
      else if (sel < 9) op = 6'h17;
      else op = 6'($urandom);
      av = ($urandom_range(0, 1) == 1) ? pool[$urandom_range(0, 11)] : {$urandom, $urandom};
      bv = {$urandom, $urandom};
      pc = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: d = 21'h0FFFFF;
        1: d = 21'h100000;
        default: d = 21'($urandom);
      endcase
      run("R12", op, fn, 5'($urandom_range(28, 31)), 5'($urandom_range(28, 31)),
          5'($urandom_range(28, 31)), av, bv, pc, d);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule